// File: doc/BRIEF.md
# Page-One Stack and Reset-Vector Sequencer

This block keeps an 8-bit stack pointer for a descending stack that always lives in memory page one, addresses 0x0100 to 0x01FF. It turns single commands into sequences of one-byte memory transactions on a synchronous memory port:

- byte push and byte pull;
- word push, used to save a call's return address;
- word pull, used on return to restore it;
- the three-byte save and restore frames around a software interrupt and its return;
- the two-byte load of the program counter from the reset vector.

A client raises `cmd_valid` with a command code while `busy` is low. The sequencer then runs one memory access per clock. It finishes with a one-cycle `done` pulse, after which the results on `pull_data`, `pc_out` and `status_out` are valid.

When reset is released the sequencer sets the stack pointer and fetches the program counter from the reset vector by itself. A command can repeat that sequence later.

Top module: `stack_seq`

## Requirements
- R1: Every stack access uses address {0x01, stack pointer}. No write ever leaves page one, and the only reads outside page one are the two reset-vector bytes.
- R2: Push byte (code 0) writes `wdata[7:0]` to 0x0100+SP and then decrements SP. Pull byte (code 1) first increments SP, then reads 0x0100+SP onto `pull_data`. SP wraps modulo 256.
- R3: Word push (code 2) stores `wdata[15:8]` and then `wdata[7:0]`. Word pull (code 3) reads the low byte first and then the high byte into `pc_out`.
- R4: Interrupt save (code 4) pushes `wdata[15:8]`, then `wdata[7:0]`, then `status_in` with bits 4 and 5 set. SP ends three lower.
- R5: Interrupt return (code 5) pulls the status byte onto `status_out` with bit 5 forced to 1 and bit 4 forced to 0. It then pulls the program counter, low byte first, into `pc_out`.
- R6: While reset is low, SP is 0xFD, `busy` is high and `done` is low. After release, `pc_out` is loaded from 0xFFFC (low byte) and 0xFFFD (high byte), followed by `done`. Code 6 sets SP to 0xFD and repeats the vector load.
- R7: One memory access is made per clock and `done` is high for exactly one cycle. Counted from the cycle after acceptance, `done` appears after n cycles for an n-access write sequence and after n+1 cycles for an n-access read sequence.
- R8: A command is taken only when `busy` is low. Code 7, and any command presented while `busy` is high, changes neither SP nor memory and gives no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd | input | 3 | Command code |
| wdata | input | 16 | Byte or word to push (program counter for frames) |
| status_in | input | 8 | Status byte for the interrupt save frame |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_re` |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write data |
| sp | output | 8 | Stack pointer |
| pc_out | output | 16 | Loaded program counter |
| status_out | output | 8 | Restored status byte |
| pull_data | output | 8 | Byte from the last byte pull |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench runs a long random mix of all eight command codes against a model of the stack page. Interleaving pushes and pulls of different widths exposes wrong byte order, off-by-one pointer updates and wrong flag forcing, because a mistake in one frame surfaces when a later frame is read back. Directed runs walk the pointer from 0xFD through 0xFF to 0x00 and back, which separates correct modulo wrap from page escape. A command held high during an interrupt save distinguishes real busy gating from a sequencer that restarts. Measuring the latency of every command tells apart the one-access-per-clock timing of write sequences and read sequences.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter logic [7:0]  PAGE    = 8'h01,
  parameter logic [7:0]  SP_INIT = 8'hFD,
  parameter logic [15:0] VEC     = 16'hFFFC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd,
  input  logic [15:0] wdata,
  input  logic [7:0]  status_in,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] mem_addr,
  output logic        mem_we,
  output logic        mem_re,
  output logic [7:0]  mem_wdata,
  output logic [7:0]  sp,
  output logic [15:0] pc_out,
  output logic [7:0]  status_out,
  output logic [7:0]  pull_data,
  output logic        busy,
  output logic        done
);
  localparam logic [2:0] C_PUSHB = 3'd0, C_PULLB = 3'd1, C_PUSHW = 3'd2, C_PULLW = 3'd3,
                         C_SAVE  = 3'd4, C_REST  = 3'd5, C_VECT  = 3'd6, C_NONE  = 3'd7;

  logic [2:0]  op;
  logic [1:0]  idx, cap_idx, nacc;
  logic        cap_v, rd_op, act, last, fin;
  logic [15:0] wd_q;
  logic [7:0]  st_q;

  always_comb begin
    case (op)
      C_PUSHB, C_PULLB:         nacc = 2'd1;
      C_PUSHW, C_PULLW, C_VECT: nacc = 2'd2;
      C_SAVE, C_REST:           nacc = 2'd3;
      default:                  nacc = 2'd0;
    endcase
  end

  assign rd_op = (op == C_PULLB) || (op == C_PULLW) || (op == C_REST) || (op == C_VECT);
  assign act   = busy && (idx < nacc);
  assign last  = idx == nacc - 2'd1;
  assign fin   = rd_op ? (cap_v && cap_idx == nacc - 2'd1) : (act && last);

  assign mem_addr = (op == C_VECT) ? VEC + {14'd0, idx} : {PAGE, rd_op ? sp + 8'd1 : sp};
  assign mem_we   = act && !rd_op;
  assign mem_re   = act && rd_op;

  always_comb begin
    case (op)
      C_PUSHB: mem_wdata = wd_q[7:0];
      C_PUSHW: mem_wdata = (idx == 2'd0) ? wd_q[15:8] : wd_q[7:0];
      C_SAVE:  mem_wdata = (idx == 2'd0) ? wd_q[15:8] :
                           (idx == 2'd1) ? wd_q[7:0] : (st_q | 8'h30);
      default: mem_wdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp         <= SP_INIT;
      busy       <= 1'b1;
      op         <= C_VECT;
      idx        <= 2'd0;
      cap_v      <= 1'b0;
      cap_idx    <= 2'd0;
      done       <= 1'b0;
      pc_out     <= 16'h0000;
      status_out <= 8'h00;
      pull_data  <= 8'h00;
      wd_q       <= 16'h0000;
      st_q       <= 8'h00;
    end else begin
      done    <= fin;
      cap_v   <= mem_re;
      cap_idx <= idx;
      if (!busy) begin
        if (cmd_valid && cmd != C_NONE) begin
          busy <= 1'b1;
          op   <= cmd;
          idx  <= 2'd0;
          wd_q <= wdata;
          st_q <= status_in;
          if (cmd == C_VECT) sp <= SP_INIT;
        end
      end else begin
        if (act) begin
          idx <= idx + 2'd1;
          if (op != C_VECT) sp <= rd_op ? sp + 8'd1 : sp - 8'd1;
        end
        if (cap_v) begin
          case (op)
            C_PULLB: pull_data <= mem_rdata;
            C_PULLW, C_VECT:
              if (cap_idx == 2'd0) pc_out[7:0] <= mem_rdata;
              else                 pc_out[15:8] <= mem_rdata;
            C_REST:
              if (cap_idx == 2'd0)      status_out <= {mem_rdata[7:6], 2'b10, mem_rdata[3:0]};
              else if (cap_idx == 2'd1) pc_out[7:0] <= mem_rdata;
              else                      pc_out[15:8] <= mem_rdata;
            default: ;
          endcase
        end
        if (fin) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [2:0]  cmd,
  input logic        busy,
  input logic        done,
  input logic        mem_we,
  input logic        mem_re,
  input logic [15:0] mem_addr,
  input logic [7:0]  sp
);
  p_wr_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[15:8] == 8'h01 && mem_addr[7:0] == sp));

  p_rd_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (mem_addr[15:8] == 8'h01 || mem_addr == 16'hFFFC || mem_addr == 16'hFFFD));

  p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp == $past(sp) - 8'd1);

  p_pull_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && mem_addr[15:8] == 8'h01) |=> sp == $past(sp) + 8'd1);

  p_one_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(cmd_valid && cmd == 3'd6)) |=> $stable(sp));
endmodule

bind stack_seq stack_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .busy(busy),
  .done(done), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .sp(sp)
);

// File: tb/test_stack_seq.sv
`timescale 1ns/1ps
module test_stack_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [15:0] wdata = 16'h0;
  logic [7:0]  status_in = 8'h0;
  logic [7:0]  mem_rdata = 8'h0;
  logic [15:0] mem_addr, pc_out;
  logic        mem_we, mem_re, busy, done;
  logic [7:0]  mem_wdata, sp, status_out, pull_data;

  logic [7:0] page [256];
  logic [7:0] mdl [256];
  logic [7:0] vlo = 8'h34, vhi = 8'hC2;
  logic [7:0] msp, ep, est;
  logic [15:0] epc;
  int nchk = 0, nerr = 0;

  stack_seq i_stack_seq (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (mem_we) begin
      if (mem_addr[15:8] != 8'h01) begin
        nerr++;
        $display("FAIL R1 actual=%h expected=01xx", mem_addr);
      end else page[mem_addr[7:0]] <= mem_wdata;
    end
    if (mem_re)
      mem_rdata <= (mem_addr[15:8] == 8'h01) ? page[mem_addr[7:0]] :
                   (mem_addr == 16'hFFFC) ? vlo : (mem_addr == 16'hFFFD) ? vhi : 8'hEE;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
  endtask

  task automatic do_op(input logic [2:0] c, input logic [15:0] w, input logic [7:0] s);
    int lat, elat;
    logic [7:0] sp0;
    sp0 = sp;
    case (c)
      3'd0: begin mdl[msp] = w[7:0]; msp--; elat = 1; end
      3'd1: begin msp++; ep = mdl[msp]; elat = 2; end
      3'd2: begin mdl[msp] = w[15:8]; msp--; mdl[msp] = w[7:0]; msp--; elat = 2; end
      3'd3: begin msp++; epc[7:0] = mdl[msp]; msp++; epc[15:8] = mdl[msp]; elat = 3; end
      3'd4: begin mdl[msp] = w[15:8]; msp--; mdl[msp] = w[7:0]; msp--;
                  mdl[msp] = s | 8'h30; msp--; elat = 3; end
      3'd5: begin msp++; est = (mdl[msp] | 8'h20) & 8'hEF; msp++; epc[7:0] = mdl[msp];
                  msp++; epc[15:8] = mdl[msp]; elat = 4; end
      3'd6: begin msp = 8'hFD; epc = {vhi, vlo}; elat = 3; end
      default: elat = 20;
    endcase
    while (busy) @(negedge clk);
    cmd_valid = 1'b1; cmd = c; wdata = w; status_in = s;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done(lat);
    chk(c == 3'd7 ? "R8 no done" : "R7 latency", lat, elat);
    if (c != 3'd7) begin
      @(negedge clk);
      chk("R7 done one cycle", done, 0);
    end
    chk(c == 3'd7 ? "R8 sp held" : "R2 sp", sp, c == 3'd7 ? sp0 : msp);
    case (c)
      3'd0: chk("R2 push byte mem", page[msp + 8'd1], mdl[msp + 8'd1]);
      3'd1: chk("R2 pull byte", pull_data, ep);
      3'd2: chk("R3 word push mem", {page[msp + 8'd2], page[msp + 8'd1]},
                {mdl[msp + 8'd2], mdl[msp + 8'd1]});
      3'd3: chk("R3 word pull", pc_out, epc);
      3'd4: chk("R4 frame mem", {page[msp + 8'd3], page[msp + 8'd2], page[msp + 8'd1]},
                {mdl[msp + 8'd3], mdl[msp + 8'd2], mdl[msp + 8'd1]});
      3'd5: begin chk("R5 status", status_out, est); chk("R5 pc", pc_out, epc); end
      3'd6: chk("R6 vector", pc_out, epc);
      default: ;
    endcase
  endtask

  initial begin
    int lat;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin page[i] = 8'(i) ^ 8'h5A; mdl[i] = 8'(i) ^ 8'h5A; end
    repeat (2) @(negedge clk);
    chk("R6 reset sp", sp, 8'hFD);
    chk("R6 reset busy", busy, 1);
    chk("R6 reset done", done, 0);
    rst_n = 1'b1;
    wait_done(lat);
    chk("R6 reset vector", pc_out, 16'hC234);
    chk("R6 sp after vector", sp, 8'hFD);
    msp = 8'hFD;

    do_op(3'd1, 16'h0, 8'h0);
    do_op(3'd1, 16'h0, 8'h0);
    do_op(3'd1, 16'h0, 8'h0);
    chk("R2 wrap to 00", sp, 8'h00);
    do_op(3'd0, 16'h00A7, 8'h0);
    chk("R2 push at 0100", page[0], 8'hA7);
    chk("R2 wrap to FF", sp, 8'hFF);
    do_op(3'd1, 16'h0, 8'h0);
    chk("R2 pull from 0100", pull_data, 8'hA7);

    do_op(3'd2, 16'h8E21, 8'h0);
    do_op(3'd3, 16'h0, 8'h0);
    chk("R3 round trip", pc_out, 16'h8E21);
    do_op(3'd4, 16'h4410, 8'hC3);
    do_op(3'd5, 16'h0, 8'h0);
    chk("R5 round trip status", status_out, 8'hE3);
    chk("R5 round trip pc", pc_out, 16'h4410);
    do_op(3'd7, 16'h1111, 8'h0);

    while (busy) @(negedge clk);
    cmd_valid = 1'b1; cmd = 3'd4; wdata = 16'h1357; status_in = 8'h01;
    @(negedge clk);
    cmd = 3'd0; wdata = 16'h00FF;
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done(lat);
    mdl[msp] = 8'h13; msp--; mdl[msp] = 8'h57; msp--; mdl[msp] = 8'h31; msp--;
    repeat (3) @(negedge clk);
    chk("R8 busy ignore sp", sp, msp);
    chk("R8 busy ignore mem", page[msp + 8'd1], 8'h31);

    vlo = 8'h00; vhi = 8'hF0;
    do_op(3'd6, 16'h0, 8'h0);

    for (int k = 0; k < 300; k++) begin
      logic [2:0] c;
      c = 3'($urandom % 8);
      if (c == 3'd6) begin vlo = 8'($urandom); vhi = 8'($urandom); end
      do_op(c, 16'($urandom), 8'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule